// File: doc/BRIEF.md
# Low-Power Mode and Clock-Gating Controller

This block decides which clock domains of a small system get a clock. Software asks for a reduced-power state by writing a one-shot mode request. The controller then drops the clock enables for the processor core, the memory system and the peripherals, and in the deepest state it also drops the oscillator enable. It brings everything back when a valid wake event arrives. The enables are meant to drive glitch-free clock-gating cells elsewhere in the chip.

There are two sleep depths, and each has its own wake sources.
- **Idle** stops only the core and memory clocks. Peripherals keep running, and any synchronous interrupt request resumes execution.
- **Power-down** stops every internal clock and the oscillator, and holds the output pins. Only clockless wake lines end it. These are asynchronous levels, qualified by a wake mask.

After a power-down wake, a programmable settle count keeps the core gated while the oscillator restarts. A per-peripheral gate register switches individual peripheral clocks off. A real-time-clock source select keeps the timekeeping clock enabled through power-down when that clock comes from an external low-rate input.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset the controller is in run. `core_clk_en`, `mem_clk_en`, `periph_clk_en`, `osc_en` and `rtc_clk_en` are 1. `pin_hold` is 0, `mode_bits` is 2'b00, and every bit of `periph_gate` is 1.
- R2: In run, a `mode_wr` with `mode_wdata` bit 0 set and bit 1 clear enters idle at the next clock edge. In idle, `core_clk_en` and `mem_clk_en` are 0, `periph_clk_en` and `osc_en` stay 1, and `mode_bits` reads 2'b01.
- R3: In idle, any set bit of `irq` returns the controller to run at the next edge, and `mode_bits` self-clears to 2'b00. `mode_bits` is 2'b00 whenever the core clock comes back.
- R4: In run, a `mode_wr` with `mode_wdata` bit 1 set enters power-down at the next edge. In power-down, all clock enables and `osc_en` are 0, `pin_hold` is 1, and `mode_bits` reads 2'b10.
- R5: When both request bits are written together, power-down wins.
- R6: In power-down, `irq` has no effect. A wake line whose `wake_mask` bit is 0 has no effect. Only a line with both the level and the mask bit at 1 starts the wake.
- R7: A qualified wake passes a two-stage synchronizer, then enters a settle phase of `settle_cycles`+1 cycles. During settle, `osc_en` is 1 and the core, memory and peripheral enables are 0. `core_clk_en` returns `settle_cycles`+4 clock edges after the wake level is first seen at an edge.
- R8: `rtc_clk_en` is 1 in run and idle. In power-down and settle it equals `rtc_ext_sel` (1 = external low-rate source).
- R9: `periph_gate[i]` is the stored gate bit i ANDed with `periph_clk_en`. A `pcon_wr` in run loads the stored bits, and a 0 bit turns that peripheral off.
- R10: `mode_wr` and `pcon_wr` are ignored outside run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode request write strobe |
| mode_wdata | input | 2 | Bit 0 idle request, bit 1 power-down request |
| irq | input | NIRQ | Synchronous interrupt requests (idle wake) |
| async_wake | input | NWAKE | Clockless wake levels (power-down wake) |
| wake_mask | input | NWAKE | Per-line wake enable |
| pcon_wr | input | 1 | Peripheral gate register write strobe |
| pcon_wdata | input | NPERIPH | New peripheral gate bits |
| rtc_ext_sel | input | 1 | 1 = real-time clock from external low-rate input |
| settle_cycles | input | SETTLE_W | Oscillator settle count |
| core_clk_en | output | 1 | Processor core clock enable |
| mem_clk_en | output | 1 | Memory and internal bus clock enable |
| periph_clk_en | output | 1 | Peripheral domain clock enable |
| periph_gate | output | NPERIPH | Per-peripheral clock enables |
| osc_en | output | 1 | Oscillator enable |
| rtc_clk_en | output | 1 | Real-time-clock clock enable |
| pin_hold | output | 1 | Holds output pin levels static |
| mode_bits | output | 2 | Read-back of the mode request register |

## Verification
The bench builds the block with 8 peripherals, 4 interrupt lines, 4 wake lines and a 6-bit settle counter. With these values every gate bit pattern and wake-line combination can be reached from random stimulus, and the settle count can run from zero to 63. Settle values are drawn in the 0 to 15 range, so the exact wake latency is checked many times, including the zero-count case.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_IDLE   = 2'd1,
    ST_PDOWN  = 2'd2,
    ST_SETTLE = 2'd3
  } lpm_state_e;

  localparam int REQ_IDLE_BIT  = 0;
  localparam int REQ_PDOWN_BIT = 1;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[i] <= 1'b0;
        stage2_q[i] <= 1'b0;
      end else begin
        stage1_q[i] <= d[i];
        stage2_q[i] <= stage1_q[i];
      end
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int SETTLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_wr,
  input  logic [1:0]          mode_wdata,
  input  logic                irq_any,
  input  logic                wake_any,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output lpm_state_e          state,
  output logic [1:0]          mode_bits
);
  lpm_state_e          state_q, state_d;
  logic [1:0]          mode_q, mode_d;
  logic [SETTLE_W-1:0] cnt_q, cnt_d;
  logic                cnt_en;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      ST_RUN: begin
        if (mode_wr && mode_wdata[REQ_PDOWN_BIT]) begin
          state_d = ST_PDOWN;
          mode_d  = 2'b10;
        end else if (mode_wr && mode_wdata[REQ_IDLE_BIT]) begin
          state_d = ST_IDLE;
          mode_d  = 2'b01;
        end
      end
      ST_IDLE: begin
        if (irq_any) begin
          state_d = ST_RUN;
          mode_d  = 2'b00;
        end
      end
      ST_PDOWN: begin
        if (wake_any) begin
          state_d = ST_SETTLE;
          cnt_d   = settle_cycles;
          cnt_en  = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (cnt_q == '0) begin
          state_d = ST_RUN;
          mode_d  = 2'b00;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      mode_q  <= 2'b00;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign state     = state_q;
  assign mode_bits = mode_q;
endmodule

// File: rtl/lpm_gate.sv
module lpm_gate
  import lpm_pkg::*;
#(
  parameter int NPERIPH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  lpm_state_e         state,
  input  logic               pcon_wr,
  input  logic [NPERIPH-1:0] pcon_wdata,
  input  logic               rtc_ext_sel,
  output logic               core_clk_en,
  output logic               mem_clk_en,
  output logic               periph_clk_en,
  output logic [NPERIPH-1:0] periph_gate,
  output logic               osc_en,
  output logic               rtc_clk_en,
  output logic               pin_hold
);
  logic [NPERIPH-1:0] pcon_q;
  logic               pcon_en;

  assign pcon_en = pcon_wr && (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcon_q <= '1;
    else if (pcon_en) pcon_q <= pcon_wdata;
  end

  always_comb begin
    core_clk_en   = 1'b0;
    mem_clk_en    = 1'b0;
    periph_clk_en = 1'b0;
    osc_en        = 1'b0;
    rtc_clk_en    = rtc_ext_sel;
    pin_hold      = 1'b0;
    case (state)
      ST_RUN: begin
        core_clk_en   = 1'b1;
        mem_clk_en    = 1'b1;
        periph_clk_en = 1'b1;
        osc_en        = 1'b1;
        rtc_clk_en    = 1'b1;
      end
      ST_IDLE: begin
        periph_clk_en = 1'b1;
        osc_en        = 1'b1;
        rtc_clk_en    = 1'b1;
      end
      ST_PDOWN:  pin_hold = 1'b1;
      ST_SETTLE: begin
        osc_en   = 1'b1;
        pin_hold = 1'b1;
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < NPERIPH; i++) begin : g_gate
    assign periph_gate[i] = pcon_q[i] & periph_clk_en;
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NPERIPH  = 16,
  parameter int NIRQ     = 8,
  parameter int NWAKE    = 4,
  parameter int SETTLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_wr,
  input  logic [1:0]          mode_wdata,
  input  logic [NIRQ-1:0]     irq,
  input  logic [NWAKE-1:0]    async_wake,
  input  logic [NWAKE-1:0]    wake_mask,
  input  logic                pcon_wr,
  input  logic [NPERIPH-1:0]  pcon_wdata,
  input  logic                rtc_ext_sel,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic                core_clk_en,
  output logic                mem_clk_en,
  output logic                periph_clk_en,
  output logic [NPERIPH-1:0]  periph_gate,
  output logic                osc_en,
  output logic                rtc_clk_en,
  output logic                pin_hold,
  output logic [1:0]          mode_bits
);
  logic             rst_meta_q, rst_sync_n;
  logic [NWAKE-1:0] wake_qual, wake_sync;
  logic             wake_seen;
  lpm_state_e       state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign wake_qual = async_wake & wake_mask;

  lpm_sync #(.W(NWAKE)) u_wsync (
    .clk(clk), .rst_n(rst_sync_n), .d(wake_qual), .q(wake_sync)
  );

  assign wake_seen = |wake_sync;

  lpm_seq #(.SETTLE_W(SETTLE_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .irq_any(|irq), .wake_any(wake_seen), .settle_cycles(settle_cycles),
    .state(state), .mode_bits(mode_bits)
  );

  lpm_gate #(.NPERIPH(NPERIPH)) u_gate (
    .clk(clk), .rst_n(rst_sync_n), .state(state), .pcon_wr(pcon_wr),
    .pcon_wdata(pcon_wdata), .rtc_ext_sel(rtc_ext_sel),
    .core_clk_en(core_clk_en), .mem_clk_en(mem_clk_en),
    .periph_clk_en(periph_clk_en), .periph_gate(periph_gate),
    .osc_en(osc_en), .rtc_clk_en(rtc_clk_en), .pin_hold(pin_hold)
  );
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
  import lpm_pkg::*;
#(
  parameter int NPERIPH = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_wr,
  input logic [1:0]         mode_wdata,
  input lpm_state_e         state,
  input logic               wake_seen,
  input logic               core_clk_en,
  input logic               mem_clk_en,
  input logic               periph_clk_en,
  input logic [NPERIPH-1:0] periph_gate,
  input logic               osc_en,
  input logic               rtc_clk_en,
  input logic               rtc_ext_sel,
  input logic               pin_hold,
  input logic [1:0]         mode_bits
);
  // R2
  idle_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!core_clk_en && !mem_clk_en && periph_clk_en && osc_en));

  // R3
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_clk_en) |-> (mode_bits == 2'b00));

  // R4
  pd_clocks_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PDOWN) |-> (!core_clk_en && !mem_clk_en && !periph_clk_en && !osc_en && pin_hold));

  // R5
  pd_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && mode_wr && mode_wdata[1]) |=> (state == ST_PDOWN));

  // R6
  pd_wake_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PDOWN && !wake_seen) |=> (state == ST_PDOWN));

  // R7
  settle_core_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SETTLE) |-> (osc_en && !core_clk_en && !periph_clk_en));

  // R8
  rtc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (rtc_clk_en == rtc_ext_sel));

  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_clk_en |-> (periph_gate == '0));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NPERIPH(NPERIPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
  .state(state), .wake_seen(wake_seen), .core_clk_en(core_clk_en),
  .mem_clk_en(mem_clk_en), .periph_clk_en(periph_clk_en),
  .periph_gate(periph_gate), .osc_en(osc_en), .rtc_clk_en(rtc_clk_en),
  .rtc_ext_sel(rtc_ext_sel), .pin_hold(pin_hold), .mode_bits(mode_bits)
);

// File: tb/lpm_ctrl_test.sv
module lpm_ctrl_test;
  localparam int NP = 8, NI = 4, NW = 4, SW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_wr;
  logic [1:0]    mode_wdata;
  logic [NI-1:0] irq;
  logic [NW-1:0] async_wake, wake_mask;
  logic          pcon_wr;
  logic [NP-1:0] pcon_wdata;
  logic          rtc_ext_sel;
  logic [SW-1:0] settle_cycles;
  logic          core_clk_en, mem_clk_en, periph_clk_en, osc_en, rtc_clk_en, pin_hold;
  logic [NP-1:0] periph_gate;
  logic [1:0]    mode_bits;

  int checks = 0, fails = 0;
  logic [NP-1:0] pcon_model;
  bit done = 0;

  always #5 clk = ~clk;

  lpm_ctrl #(.NPERIPH(NP), .NIRQ(NI), .NWAKE(NW), .SETTLE_W(SW)) uut (.*);

  function automatic logic [NP-1:0] exp_gate(logic [NP-1:0] p, logic en);
    return en ? p : '0;
  endfunction

  // packed {core, mem, periph, osc, rtc, hold} for run=0 idle=1 pdown=2 settle=3
  function automatic logic [5:0] exp_clk(int st, logic sel);
    case (st)
      0:       return 6'b111110;
      1:       return 6'b001110;
      2:       return {4'b0000, sel, 1'b1};
      default: return {4'b0001, sel, 1'b1};
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] clk_vec();
    return {core_clk_en, mem_clk_en, periph_clk_en, osc_en, rtc_clk_en, pin_hold};
  endfunction

  task automatic write_mode(logic [1:0] v);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk); mode_wr = 1'b0; mode_wdata = 2'b00;
  endtask

  task automatic write_pcon(logic [NP-1:0] v);
    @(negedge clk); pcon_wr = 1'b1; pcon_wdata = v;
    @(negedge clk); pcon_wr = 1'b0;
  endtask

  task automatic pd_wake(int s, logic [NW-1:0] lines);
    int n = 0;
    settle_cycles = SW'(s);
    async_wake = lines;
    wake_mask = lines | NW'($urandom);
    while (!core_clk_en && n < 200) begin
      @(negedge clk); n++;
      if (n == 1) chk("R6 still asleep one edge after wake", clk_vec(), exp_clk(2, rtc_ext_sel));
      if (n == 3) chk("R7 settle phase clocks", clk_vec(), exp_clk(3, rtc_ext_sel));
    end
    chk("R7 core returns after settle+4 edges", n, s + 4);
    chk("R3 mode bits clear after power-down wake", mode_bits, 2'b00);
    async_wake = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; mode_wr = 0; mode_wdata = 0; irq = 0; async_wake = 0;
    wake_mask = 0; pcon_wr = 0; pcon_wdata = 0; rtc_ext_sel = 0; settle_cycles = 0;
    pcon_model = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 clocks after reset", clk_vec(), exp_clk(0, 1'b0));
    chk("R1 gate bits after reset", periph_gate, {NP{1'b1}});
    chk("R1 mode bits after reset", mode_bits, 2'b00);

    // R9 random gate writes in run
    for (int i = 0; i < 8; i++) begin
      logic [NP-1:0] v = NP'($urandom);
      write_pcon(v); pcon_model = v;
      chk("R9 gate follows written bits in run", periph_gate, exp_gate(pcon_model, 1'b1));
    end

    // R2/R3/R10 idle
    write_mode(2'b01);
    chk("R2 idle clocks", clk_vec(), exp_clk(1, rtc_ext_sel));
    chk("R2 idle mode bits", mode_bits, 2'b01);
    chk("R9 gate kept in idle", periph_gate, exp_gate(pcon_model, 1'b1));
    write_pcon(~pcon_model);
    chk("R10 gate write ignored in idle", periph_gate, exp_gate(pcon_model, 1'b1));
    write_mode(2'b10);
    chk("R10 mode write ignored in idle", mode_bits, 2'b01);
    async_wake = '1; wake_mask = '1;
    repeat (4) @(negedge clk);
    chk("R3 idle not ended by wake lines without irq", clk_vec(), exp_clk(1, rtc_ext_sel));
    async_wake = '0;
    @(negedge clk); irq = 4'b0100;
    @(negedge clk); irq = '0;
    chk("R3 irq ends idle", clk_vec(), exp_clk(0, rtc_ext_sel));
    chk("R3 mode bits self-clear", mode_bits, 2'b00);

    // R5 priority, R8 rtc source, R6 masked/irq ignored
    rtc_ext_sel = 1'b1;
    write_mode(2'b11);
    chk("R5 both bits give power-down", mode_bits, 2'b10);
    chk("R4 R8 power-down clocks with external rtc", clk_vec(), exp_clk(2, 1'b1));
    chk("R4 gate off in power-down", periph_gate, '0);
    irq = '1; async_wake = 4'b0011; wake_mask = 4'b1100;
    repeat (6) @(negedge clk);
    chk("R6 irq and masked wake ignored", clk_vec(), exp_clk(2, 1'b1));
    write_pcon('0);
    irq = '0; async_wake = '0;
    pd_wake(0, 4'b1000);
    chk("R10 gate write ignored in power-down", periph_gate, exp_gate(pcon_model, 1'b1));

    // random mix
    for (int i = 0; i < 40; i++) begin
      rtc_ext_sel = 1'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        write_mode(2'b01);
        chk("R2 random idle entry", clk_vec(), exp_clk(1, rtc_ext_sel));
        repeat ($urandom_range(0, 5)) @(negedge clk);
        irq = NI'($urandom_range(1, (1 << NI) - 1));
        @(negedge clk); irq = '0;
        chk("R3 random irq wake", clk_vec(), exp_clk(0, rtc_ext_sel));
      end else begin
        write_mode(2'b10);
        chk("R4 R8 random power-down", clk_vec(), exp_clk(2, rtc_ext_sel));
        pd_wake($urandom_range(0, 15), NW'(1 << $urandom_range(0, NW - 1)));
      end
      chk("R9 gate after wake", periph_gate, exp_gate(pcon_model, 1'b1));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule